// File: doc/BRIEF.md
# FFSK Transmit Byte Framer

This block turns bytes written by a host into a serial bit stream for a downstream FFSK modulator. One bit goes out on each enabled bit-rate strobe, most significant bit first. A one-byte holding register sits in front of the shift register, so the host can load the next byte while the current one is being sent. The tone synthesis and the baud-rate divider sit outside the block. The only timing reference is `bit_stb_i`.

The host marks a checksum span by holding `sum_en_i` high. Every byte whose first bit leaves while the level is high is divided by the degree-15 generator x^15+x^14+x^13+x^11+x^4+x^2+1. When the level drops, the byte in flight finishes. The block then inserts a 16-bit word made of the 15 remainder bits, with the final remainder bit inverted, and one even-parity bit taken over the span data and those 15 bits. When nothing is left to send, one hang bit repeats the last bit and the transmitter reports idle. A pulse on `empty_o` tells the host when the holding register can accept a byte.

Top module: `ffsk_tx_framer`

## Requirements
- R1: After reset, `bit_vld_o`, `empty_o` and `idle_o` are low. Every pulse on these outputs lasts one clock and appears one clock after an enabled `bit_stb_i`. `bit_o` is valid while `bit_vld_o` is high.
- R2: A byte written while the transmitter is idle sends its bit 7 on the first strobe at or after the write, then bits 6 down to 0 on the next seven strobes. `empty_o` pulses on the strobe that sends bit 7.
- R3: A byte written while another byte is on the line follows it on the very next strobe, with no gap.
- R4: A write in the same cycle as a byte-boundary strobe, with the holding register empty, is sent from that strobe. `empty_o` still pulses at that boundary.
- R5: A byte joins the checksum only if `sum_en_i` is high on the strobe that sends its bit 7. A rising edge of `sum_en_i` clears the remainder and the parity.
- R6: After `sum_en_i` falls, the byte in flight completes and 16 checksum bits follow at once. First come remainder bits 14 down to 1, then inverted remainder bit 0, then the even-parity bit.
- R7: No `empty_o` pulse is raised where the checksum starts. The next pulse comes 24 strobes after the pulse of the last span byte.
- R8: At a boundary with nothing to send, one hang bit equal to the previous bit is sent and `empty_o` pulses. `idle_o` pulses on the next strobe, with no bit on that strobe.
- R9: While the transmitter is enabled and idle, `empty_o` pulses every 8 strobes.
- R10: While `tx_en_i` is low, no output pulses and writes are ignored. A byte held when the enable drops is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable; low flushes all state |
| bit_stb_i | input | 1 | One-cycle strobe per bit period |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to send |
| sum_en_i | input | 1 | Checksum span level |
| bit_o | output | 1 | Serial bit |
| bit_vld_o | output | 1 | One-clock pulse: new bit on `bit_o` |
| empty_o | output | 1 | One-clock pulse: holding register free |
| idle_o | output | 1 | One-clock pulse: transmission finished |

## Verification
The host write and the byte-boundary strobe can land in the same clock. In that case the refill and the selection of the next byte meet in one cycle. The bench places a write exactly on the strobe that ends a byte while the holding register is empty. It then judges the captured stream: the new byte must start on that strobe with no hang bit in between, and an empty pulse must still be raised at that boundary. A second coincidence comes from dropping the span level. The checksum must follow the byte in flight, and the empty-pulse gap is measured in strobes.

// File: rtl/ffsk_tx_pkg.sv
package ffsk_tx_pkg;
  localparam int CHK_W = 16;
  localparam int REM_W = CHK_W - 1;
  // x^15 implied; x^14 + x^13 + x^11 + x^4 + x^2 + 1
  localparam logic [REM_W-1:0] CRC_POLY = 15'h6815;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_HANG = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ffsk_chk_acc.sv
module ffsk_chk_acc
  import ffsk_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             feed_i,
  input  logic             bit_i,
  output logic [CHK_W-1:0] word_o
);
  logic [REM_W-1:0] rem_q, rem_base, rem_step, rem_adj;
  logic par_q, par_base, fb;

  always_comb begin
    rem_base = clr_i ? '0 : rem_q;
    par_base = clr_i ? 1'b0 : par_q;
    fb       = bit_i ^ rem_base[REM_W-1];
    rem_step = {rem_base[REM_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      par_q <= 1'b0;
    end else if (feed_i) begin
      rem_q <= rem_step;
      par_q <= par_base ^ bit_i;
    end else begin
      rem_q <= rem_base;
      par_q <= par_base;
    end
  end

  assign rem_adj = {rem_q[REM_W-1:1], ~rem_q[0]};
  assign word_o  = {rem_adj, par_q ^ (^rem_adj)};
endmodule

// File: rtl/ffsk_tx_hold.sv
module ffsk_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic              avail_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (flush_i) begin
      full_q <= 1'b0;
    end else if (take_i) begin
      // bypass when empty; refill when full and written together
      if (full_q && wr_i) buf_q <= data_i;
      else                full_q <= 1'b0;
    end else if (wr_i) begin
      buf_q  <= data_i;
      full_q <= 1'b1;
    end
  end

  assign full_o  = full_q;
  assign avail_o = full_q | wr_i;
  assign data_o  = full_q ? buf_q : data_i;
endmodule

// File: rtl/ffsk_tx_framer.sv
module ffsk_tx_framer
  import ffsk_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              bit_stb_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sum_en_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              empty_o,
  output logic              idle_o
);
  localparam int SH_W  = CHK_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam int IC_W  = $clog2(DATA_W);
  localparam int PAD_W = SH_W - DATA_W + 1;

  tx_state_e         state_q, state_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [IC_W-1:0]   icnt_q, icnt_d;
  logic              span_q, span_d, pend_q, pend_d, sum_q;
  logic              bit_q, vld_q, empty_q, idle_q;
  logic              emit, emit_bit, empty_p, idle_p;
  logic              stb, rise, fall, take, feed, feed_bit;
  logic              hold_full, hold_avail;
  logic [DATA_W-1:0] hold_data;
  logic [CHK_W-1:0]  chk_word;

  assign stb  = bit_stb_i & tx_en_i;
  assign rise = sum_en_i & ~sum_q;
  assign fall = ~sum_en_i & sum_q;

  ffsk_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (~tx_en_i),
    .wr_i    (wr_i & tx_en_i),
    .data_i  (wr_data_i),
    .take_i  (take),
    .full_o  (hold_full),
    .avail_o (hold_avail),
    .data_o  (hold_data)
  );

  ffsk_chk_acc u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rise),
    .feed_i (feed),
    .bit_i  (feed_bit),
    .word_o (chk_word)
  );

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    left_d   = left_q;
    icnt_d   = icnt_q;
    span_d   = span_q;
    pend_d   = pend_q | fall;
    emit     = 1'b0;
    emit_bit = bit_q;
    empty_p  = 1'b0;
    idle_p   = 1'b0;
    take     = 1'b0;
    feed     = 1'b0;
    feed_bit = 1'b0;
    if (stb) begin
      if (state_q == TX_HANG) begin
        idle_p  = 1'b1;
        state_d = TX_IDLE;
        icnt_d  = IC_W'(1);
      end else if (state_q == TX_SEND && left_q != '0) begin
        emit     = 1'b1;
        emit_bit = sh_q[SH_W-1];
        sh_d     = {sh_q[SH_W-2:0], 1'b0};
        left_d   = left_q - 1'b1;
        feed     = span_q;
        feed_bit = sh_q[SH_W-1];
      end else if (pend_q | fall) begin
        emit     = 1'b1;
        emit_bit = chk_word[CHK_W-1];
        sh_d     = {chk_word[CHK_W-2:0], 1'b0};
        left_d   = CNT_W'(CHK_W - 1);
        span_d   = 1'b0;
        pend_d   = 1'b0;
        state_d  = TX_SEND;
      end else if (hold_avail) begin
        take     = 1'b1;
        emit     = 1'b1;
        emit_bit = hold_data[DATA_W-1];
        sh_d     = {hold_data[DATA_W-2:0], {PAD_W{1'b0}}};
        left_d   = CNT_W'(DATA_W - 1);
        span_d   = sum_en_i;
        feed     = sum_en_i;
        feed_bit = hold_data[DATA_W-1];
        empty_p  = ~(hold_full & wr_i);
        state_d  = TX_SEND;
      end else if (state_q == TX_SEND) begin
        emit    = 1'b1;
        empty_p = 1'b1;
        state_d = TX_HANG;
      end else if (icnt_q == IC_W'(DATA_W - 1)) begin
        empty_p = 1'b1;
        icnt_d  = '0;
      end else begin
        icnt_d = icnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      icnt_q  <= '0;
      span_q  <= 1'b0;
      pend_q  <= 1'b0;
      sum_q   <= 1'b0;
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
      empty_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      sum_q <= sum_en_i;
      if (!tx_en_i) begin
        state_q <= TX_IDLE;
        left_q  <= '0;
        icnt_q  <= '0;
        span_q  <= 1'b0;
        pend_q  <= 1'b0;
        vld_q   <= 1'b0;
        empty_q <= 1'b0;
        idle_q  <= 1'b0;
      end else begin
        state_q <= state_d;
        sh_q    <= sh_d;
        left_q  <= left_d;
        icnt_q  <= icnt_d;
        span_q  <= span_d;
        pend_q  <= pend_d;
        bit_q   <= emit_bit;
        vld_q   <= emit;
        empty_q <= empty_p;
        idle_q  <= idle_p;
      end
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
  assign empty_o   = empty_q;
  assign idle_o    = idle_q;
endmodule

// File: rtl/ffsk_tx_framer_chk.sv
module ffsk_tx_framer_chk #(
  parameter int GAP_MAX = 40
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic bit_stb_i,
  input logic bit_vld_o,
  input logic empty_o,
  input logic idle_o
);
  logic [7:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gap_q <= '0;
    else if (!tx_en_i || empty_o) gap_q <= '0;
    else if (bit_stb_i && gap_q != 8'hff) gap_q <= gap_q + 1'b1;
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(bit_stb_i && tx_en_i)); // R1
  AST_EMPTY_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> $past(bit_stb_i && tx_en_i)); // R1
  AST_IDLE_NO_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !bit_vld_o && !empty_o); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_en_i) |-> !(bit_vld_o || empty_o || idle_o)); // R10
  AST_EMPTY_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |-> gap_q <= 8'(GAP_MAX)); // R9
endmodule

bind ffsk_tx_framer ffsk_tx_framer_chk u_chk_bind (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .bit_stb_i (bit_stb_i),
  .bit_vld_o (bit_vld_o),
  .empty_o   (empty_o),
  .idle_o    (idle_o)
);

// File: tb/sim_ffsk_tx_framer.sv
module sim_ffsk_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       bit_stb = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sum_en = 1'b0;
  logic       bit_o, bit_vld, empty, idle;

  int checks = 0, fails = 0, cyc = 0, stb_count = 0;
  int nbits = 0, n_empty = 0, n_idle = 0, last_wr_stb = 0;
  bit done = 1'b0;
  logic cap_bit [256];
  int   cap_stb [256];
  int   emp_stb [256];
  int   idl_stb [256];

  always #5 clk = ~clk;

  ffsk_tx_framer u0 (
    .clk_i (clk), .rst_ni (rst_n), .tx_en_i (tx_en), .bit_stb_i (bit_stb),
    .wr_i (wr), .wr_data_i (wr_data), .sum_en_i (sum_en),
    .bit_o (bit_o), .bit_vld_o (bit_vld), .empty_o (empty), .idle_o (idle)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_vld && nbits < 256) begin
        cap_bit[nbits] = bit_o; cap_stb[nbits] = stb_count; nbits++;
      end
      if (empty && n_empty < 256) begin emp_stb[n_empty] = stb_count; n_empty++; end
      if (idle && n_idle < 256) begin idl_stb[n_idle] = stb_count; n_idle++; end
    end
    cyc++;
    bit_stb = (cyc % 4 == 0);
    if (bit_stb) stb_count++;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [63:0] cap_vec(input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[62:0], cap_bit[i]};
    return v;
  endfunction

  function automatic logic [15:0] ref_chk(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] r = '0;
    logic [14:0] adj;
    logic        p = 1'b0;
    logic [15:0] d = {a, b};
    for (int i = 15; i >= 0; i--) begin
      logic fb;
      fb = d[i] ^ r[14];
      r  = {r[13:0], 1'b0};
      if (fb) r = r ^ 15'h6815;
      p = p ^ d[i];
    end
    adj = {r[14:1], ~r[0]};
    p = p ^ (^adj);
    return {adj, p};
  endfunction

  task automatic clear_cap();
    nbits = 0; n_empty = 0; n_idle = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); #1;
    last_wr_stb = bit_stb ? stb_count : stb_count + 1;
    wr = 1'b1; wr_data = b;
    @(negedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic wr_at_strobe(input int target, input logic [7:0] b);
    int t = 0;
    do begin @(negedge clk); #1; t++; end while (!(bit_stb && stb_count == target) && t < 2000);
    wr = 1'b1; wr_data = b;
    @(negedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic wait_empty(input int k);
    int t = 0;
    while (n_empty < k && t < 4000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (n_idle < 1 && t < 4000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic wait_strobes(input int n);
    int target = stb_count + n;
    while (stb_count < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!bit_vld && !empty && !idle, "R1 reset", {bit_vld, empty, idle}, 0);
  endtask

  task automatic t_single();
    int s;
    clear_cap();
    wr_byte(8'hA5); s = last_wr_stb;
    wait_idle();
    check(nbits == 9 && cap_vec(9) == {55'd0, 8'hA5, 1'b1}, "R2 stream", cap_vec(nbits), {55'd0, 8'hA5, 1'b1});
    check(cap_stb[0] == s, "R2 first strobe", cap_stb[0], s);
    check(emp_stb[0] == s, "R2 empty at start", emp_stb[0], s);
    check(cap_stb[8] == s + 8, "R8 hang strobe", cap_stb[8], s + 8);
    check(idl_stb[0] == s + 9, "R8 idle strobe", idl_stb[0], s + 9);
  endtask

  task automatic t_back2back();
    int s;
    clear_cap();
    wr_byte(8'h3C); s = last_wr_stb;
    wait_empty(1);
    wr_byte(8'hC3);
    wait_idle();
    check(nbits == 17 && cap_vec(17) == {47'd0, 8'h3C, 8'hC3, 1'b1}, "R3 stream", cap_vec(nbits), {47'd0, 8'h3C, 8'hC3, 1'b1});
    check(cap_stb[16] == s + 16, "R3 no gap", cap_stb[16], s + 16);
  endtask

  task automatic t_collide();
    int s;
    clear_cap();
    wr_byte(8'h81); s = last_wr_stb;
    wr_at_strobe(s + 8, 8'h7E);
    wait_idle();
    check(nbits == 17 && cap_vec(17) == {47'd0, 8'h81, 8'h7E, 1'b0}, "R4 stream", cap_vec(nbits), {47'd0, 8'h81, 8'h7E, 1'b0});
    check(cap_stb[8] == s + 8, "R4 bypass strobe", cap_stb[8], s + 8);
    check(n_empty > 1 && emp_stb[1] == s + 8, "R4 empty at boundary", emp_stb[1], s + 8);
  endtask

  task automatic t_checksum(input logic [7:0] p0, input logic [7:0] d0, input logic [7:0] d1);
    int s;
    logic [15:0] c;
    logic [63:0] exp;
    c = ref_chk(d0, d1);
    exp = {23'd0, p0, d0, d1, c, c[0]};
    clear_cap();
    wr_byte(p0); s = last_wr_stb;
    wait_empty(1);
    @(negedge clk); #1; sum_en = 1'b1;
    wr_byte(d0);
    wait_empty(2);
    wr_byte(d1);
    wait_empty(3);
    @(negedge clk); #1; sum_en = 1'b0;
    wait_idle();
    check(nbits == 41 && cap_vec(41) == exp, "R5 R6 checksum stream", cap_vec(nbits), exp);
    check(emp_stb[2] == s + 16, "R7 last span pulse", emp_stb[2], s + 16);
    check(n_empty == 4 && emp_stb[3] == s + 40, "R7 pulse after checksum", emp_stb[3], s + 40);
  endtask

  task automatic t_idle_empty();
    clear_cap();
    wait_strobes(24);
    check(n_empty >= 2 && emp_stb[1] - emp_stb[0] == 8, "R9 idle cadence", emp_stb[1] - emp_stb[0], 8);
    check(nbits == 0, "R9 no bits while idle", nbits, 0);
  endtask

  task automatic t_disable();
    @(negedge clk); #1; tx_en = 1'b0;
    clear_cap();
    wr_byte(8'hFF);
    wait_strobes(12);
    check(nbits == 0 && n_empty == 0 && n_idle == 0, "R10 quiet when disabled", nbits + n_empty + n_idle, 0);
    @(negedge clk); #1; tx_en = 1'b1;
    wait_strobes(12);
    check(nbits == 0, "R10 byte discarded", nbits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    tx_en = 1'b1;
    wait_strobes(10);
    t_single();
    t_back2back();
    t_collide();
    t_checksum(8'h5A, 8'h0F, 8'hE2);
    t_checksum(8'h00, 8'hB7, 8'h49);
    t_idle_empty();
    t_disable();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule